// File: doc/BRIEF.md
# Two-Entry Receive Word Buffer

This block sits between a serial receiver's shift register and a processor-style read port. When the receiver finishes a word, it gives a one-cycle completion strobe along with the word. The word carries a ninth data bit and a framing-error flag. The buffer keeps up to two such words in arrival order. Each entry holds its own ninth bit and framing flag next to its data bits, so the status shown at the port always belongs to the word at the head. A data-read strobe removes the head entry. After that strobe, the next entry's data and status appear together.

A data-available flag is high whenever at least one word is waiting. The interrupt output is that flag masked by an enable input. A word can complete while both entries are occupied and no read is being taken in the same cycle. In that case the word is discarded and a sticky overrun flag is raised. While that flag is set, no further words enter the buffer, even after space has been freed. The only way to clear the flag is to drop the receive-enable input low for at least one cycle. Completed words are also ignored while receive-enable is low.

The depth parameter must be a power of two; the default of two matches the intended use.

Top module: `rx_word_fifo`

## Requirements
- R1: After reset the buffer is empty, `avail`, `irq` and `overrun` are 0, and `rd_data`, `rd_bit9` and `rd_ferr` are all 0.
- R2: A `word_valid` strobe is accepted in the same clock edge when `rx_en` is 1, `overrun` is 0 and an entry is free (or a read is taken that cycle). `avail` is 1 from the next cycle.
- R3: Words leave in arrival order. `rd_data`, `rd_bit9` and `rd_ferr` show the head entry's own stored values. A `data_rd` strobe on a non-empty buffer advances the head at that clock edge, so the next entry's status is visible only after that read.
- R4: `avail` is 1 exactly when at least one entry is occupied. It returns to 0 in the cycle after the read that empties the buffer.
- R5: `irq` is 1 exactly when `avail` is 1 and `int_en` is 1.
- R6: A `word_valid` strobe that meets R2's other conditions, arriving while both entries are full and with no read in the same cycle, sets `overrun` from the next cycle. The word is dropped and the stored entries are unchanged.
- R7: While `overrun` is 1, `word_valid` strobes are not stored, even when an entry is free.
- R8: `overrun` stays 1 while `rx_en` is 1. It is 0 in the cycle after any cycle with `rx_en` at 0. While `rx_en` is 0, `word_valid` strobes are not stored, and the stored entries remain readable.
- R9: A `data_rd` strobe on an empty buffer changes nothing. The outputs keep showing the most recently removed word, and `avail` stays 0.
- R10: With both entries full, a `word_valid` strobe and a `data_rd` strobe in the same cycle act as a read followed by a write. The new word is stored behind the remaining one and `overrun` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable; low clears overrun and blocks storing |
| int_en | input | 1 | Interrupt enable mask |
| word_valid | input | 1 | One-cycle strobe: the receiver finished a word |
| word_data | input | DATA_W | Data bits of the finished word |
| word_bit9 | input | 1 | Ninth data bit of the finished word |
| word_ferr | input | 1 | Framing-error flag of the finished word |
| data_rd | input | 1 | Data register read strobe; removes the head entry |
| rd_data | output | DATA_W | Head entry data (last removed word when empty) |
| rd_bit9 | output | 1 | Head entry ninth bit |
| rd_ferr | output | 1 | Head entry framing-error flag |
| avail | output | 1 | At least one word waiting |
| irq | output | 1 | `avail` masked by `int_en` |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Directed sequences come first:
- Filling with two words whose ninth bit and framing flag differ separates per-entry status storage from a single shared status register.
- A third word with no read must raise overrun and leave both stored words intact.
- A word sent after a read during overrun tells a truly sticky block apart from one that merely tests fullness.
- A full-buffer read-plus-write cycle separates the read-first ordering from an overrun.
- Empty reads and a low pulse on receive-enable cover the remaining edges.

A random phase follows, with mixed strobe rates and occasional enable drops. It is compared every cycle against a queue model in the bench.

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              int_en,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_data,
  input  logic              word_bit9,
  input  logic              word_ferr,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit9,
  output logic              rd_ferr,
  output logic              avail,
  output logic              irq,
  output logic              overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] ent_data [DEPTH];
  logic              ent_bit9 [DEPTH];
  logic              ent_ferr [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, show_ptr;
  logic [CNT_W-1:0]  count;
  logic              empty, full, pop, push_req, push, drop;

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign pop      = data_rd & ~empty;
  assign push_req = word_valid & rx_en & ~overrun;
  assign push     = push_req & (~full | pop);
  assign drop     = push_req & full & ~pop;

  assign show_ptr = empty ? rd_ptr - 1'b1 : rd_ptr;
  assign rd_data  = ent_data[show_ptr];
  assign rd_bit9  = ent_bit9[show_ptr];
  assign rd_ferr  = ent_ferr[show_ptr];
  assign avail    = ~empty;
  assign irq      = avail & int_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        ent_data[i] <= '0;
        ent_bit9[i] <= 1'b0;
        ent_ferr[i] <= 1'b0;
      end
    end else if (push) begin
      ent_data[wr_ptr] <= word_data;
      ent_bit9[wr_ptr] <= word_bit9;
      ent_ferr[wr_ptr] <= word_ferr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     overrun <= 1'b0;
    else if (!rx_en) overrun <= 1'b0;
    else if (drop)  overrun <= 1'b1;
  end
endmodule

module rx_word_fifo_chk #(
  parameter int DEPTH = 2,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_en,
  input logic             int_en,
  input logic             word_valid,
  input logic             data_rd,
  input logic             avail,
  input logic             irq,
  input logic             overrun,
  input logic [CNT_W-1:0] count
);
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R5
  irq_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 || !int_en) |-> !irq);

  // R6
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(count) == CNT_W'(DEPTH) && $past(word_valid) && !$past(data_rd)));

  // R7
  overrun_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !data_rd) |=> $stable(count));

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && rx_en) |=> overrun);

  // R8
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !overrun);

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !avail && !word_valid) |=> !avail);
endmodule

bind rx_word_fifo rx_word_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .int_en(int_en),
  .word_valid(word_valid), .data_rd(data_rd), .avail(avail), .irq(irq),
  .overrun(overrun), .count(count)
);

// File: tb/tb_rx_word_fifo.sv
module tb_rx_word_fifo;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, int_en = 1'b0, word_valid = 1'b0, word_bit9 = 1'b0, word_ferr = 1'b0, data_rd = 1'b0;
  logic [DATA_W-1:0] word_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic rd_bit9, rd_ferr, avail, irq, overrun;

  always #2.5 clk = ~clk;

  rx_word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .int_en(int_en),
    .word_valid(word_valid), .word_data(word_data), .word_bit9(word_bit9),
    .word_ferr(word_ferr), .data_rd(data_rd), .rd_data(rd_data),
    .rd_bit9(rd_bit9), .rd_ferr(rd_ferr), .avail(avail), .irq(irq), .overrun(overrun)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [DATA_W+1:0] q [DEPTH];
  logic [DATA_W+1:0] last_w = '0;
  int mcount = 0;
  bit movr = 0;

  function automatic logic [DATA_W+1:0] head_word();
    return (mcount > 0) ? q[0] : last_w;
  endfunction

  task automatic check(string tag, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic compare_all();
    logic [DATA_W+1:0] h;
    h = head_word();
    check("R3 data", int'(rd_data), int'(h[DATA_W-1:0]));
    check("R3 bit9", int'(rd_bit9), int'(h[DATA_W]));
    check("R3 ferr", int'(rd_ferr), int'(h[DATA_W+1]));
    check("R2/R4 avail", int'(avail), int'(mcount > 0));
    check("R5 irq", int'(irq), int'((mcount > 0) && int_en));
    check("R6/R8 overrun", int'(overrun), int'(movr));
  endtask

  task automatic step(bit v, logic [DATA_W-1:0] d, bit b9, bit fe, bit rd, bit en, bit ie);
    bit popped;
    @(negedge clk);
    compare_all();
    word_valid = v; word_data = d; word_bit9 = b9; word_ferr = fe;
    data_rd = rd; rx_en = en; int_en = ie;
    popped = rd && (mcount > 0);
    if (popped) begin
      last_w = q[0];
      for (int i = 0; i < DEPTH - 1; i++) q[i] = q[i+1];
      mcount--;
    end
    if (v && en && !movr) begin
      if (mcount < DEPTH) begin
        q[mcount] = {fe, b9, d};
        mcount++;
      end else begin
        movr = 1;
      end
    end
    if (!en) movr = 0;
  endtask

  initial begin
    #(5 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 avail", int'(avail), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 overrun", int'(overrun), 0);
    check("R1 data", int'(rd_data), 0);
    check("R1 status", int'({rd_bit9, rd_ferr}), 0);
    rst_n = 1'b1;

    // R2 R3: two words with different status, interrupt enabled
    step(1, 8'hA5, 1, 0, 0, 1, 1);
    step(1, 8'h3C, 0, 1, 0, 1, 1);
    step(0, 8'h00, 0, 0, 0, 1, 1);
    check("R3 head status before read", int'({rd_bit9, rd_ferr}), 2);
    // R6: third word while full, no read
    step(1, 8'hEE, 1, 1, 0, 1, 1);
    step(0, 8'h00, 0, 0, 0, 1, 1);
    check("R6 overrun set", int'(overrun), 1);
    check("R6 head kept", int'(rd_data), 8'hA5);
    // R7: read frees space, word still blocked
    step(0, 8'h00, 0, 0, 1, 1, 1);
    step(1, 8'h77, 0, 0, 0, 1, 1);
    step(0, 8'h00, 0, 0, 0, 1, 1);
    check("R7 second entry head", int'(rd_data), 8'h3C);
    check("R3 second status", int'({rd_bit9, rd_ferr}), 1);
    // R4: empty buffer, R9 empty read
    step(0, 8'h00, 0, 0, 1, 1, 1);
    step(0, 8'h00, 0, 0, 0, 1, 1);
    check("R4 avail cleared", int'(avail), 0);
    step(0, 8'h00, 0, 0, 1, 1, 1);
    step(0, 8'h00, 0, 0, 0, 1, 1);
    check("R9 last word shown", int'(rd_data), 8'h3C);
    check("R9 still empty", int'(avail), 0);
    // R8: rx_en low clears overrun, words ignored while low
    step(1, 8'h11, 0, 0, 0, 0, 1);
    step(0, 8'h00, 0, 0, 0, 1, 1);
    check("R8 overrun cleared", int'(overrun), 0);
    check("R8 word ignored while disabled", int'(avail), 0);
    // R10: full plus simultaneous read and write
    step(1, 8'h21, 0, 0, 0, 1, 0);
    step(1, 8'h42, 1, 0, 0, 1, 0);
    step(1, 8'h63, 0, 1, 1, 1, 0);
    step(0, 8'h00, 0, 0, 0, 1, 0);
    check("R10 no overrun", int'(overrun), 0);
    check("R10 head after read", int'(rd_data), 8'h42);
    check("R5 irq masked", int'(irq), 0);
    step(0, 8'h00, 0, 0, 1, 1, 1);
    step(0, 8'h00, 0, 0, 0, 1, 1);
    check("R10 new word behind", int'(rd_data), 8'h63);
    check("R10 new word status", int'({rd_bit9, rd_ferr}), 1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit v, rd, en, ie;
      v  = ($urandom % 100) < ((n / 500) % 2 ? 60 : 30);
      rd = ($urandom % 100) < ((n / 700) % 2 ? 20 : 45);
      en = ($urandom % 100) < 96;
      ie = ($urandom % 100) < 70;
      step(v, DATA_W'($urandom), 1'($urandom), 1'($urandom), rd, en, ie);
    end
    step(0, 8'h00, 0, 0, 0, 1, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule